// File: doc/BRIEF.md
# Per-Channel Transmit Credit Tracker

This block sits on the transmit side of a link that carries three virtual channels: posted, non-posted and response. For each channel it tracks how many receive buffers are still free at the far end of the link. A packet may leave on a channel only while that channel holds at least one credit. The count falls in the same cycle that the packet is written into the local transmit FIFO. It rises again when the receive-side decoder reports a returned credit from the peer.

A round-robin arbiter picks at most one channel per cycle from those that have a packet waiting and a nonzero count. It grants nothing while the transmit FIFO is full. A channel with no credits stalls by itself, and the other channels keep sending. If no channel is eligible, no packet is written and the link stays idle until credits come back. A credit return that would push a count past its configured maximum is dropped and reported on an error output.

Top module: `vc_credit_tracker`

## Requirements
- R1: Each channel (index 0 posted, 1 non-posted, 2 response) keeps its own count, at bits `[ch*W +: W]` of `credit_level`, where W = clog2(MAX_CREDIT+1). Synchronous reset loads every count with INIT_CREDIT.
- R2: A channel's grant is combinational in the cycle of its request. In that same cycle `fifo_wr` is 1 and `fifo_ch` carries the channel index. The granted channel's count drops by one at the next clock edge.
- R3: A channel whose count is zero is never granted, whatever its request.
- R4: A channel with a zero count does not prevent a grant to another channel that is requesting and has credits.
- R5: A `credit_ret` bit for a channel raises that channel's count by one at the next edge.
- R6: When no channel is both requesting and credited, `chan_grant` is zero, `fifo_wr` is 0 and no count changes except through returns.
- R7: A grant and a credit return on the same channel in the same cycle leave that count unchanged.
- R8: At most one grant is made per cycle. Priority rotates, starting just after the last granted channel. After reset, channel 0 has first priority.
- R9: While `fifo_full` is 1, no channel is granted.
- R10: A credit return on a channel already at MAX_CREDIT, with no grant on it that cycle, leaves the count at MAX_CREDIT and drives `credit_err` high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NUM_CH | Per-channel packet-waiting request |
| fifo_full | input | 1 | Transmit FIFO cannot accept a write |
| credit_ret | input | NUM_CH | Per-channel decoded credit return, one credit each |
| chan_grant | output | NUM_CH | One-hot grant, doubles as that channel's schedule strobe |
| fifo_wr | output | 1 | Write strobe into the transmit FIFO |
| fifo_ch | output | CH_IDX_W | Channel index of the packet being written |
| credit_level | output | NUM_CH*W | Current credit count of every channel |
| credit_err | output | 1 | Pulse after a return beyond the maximum was dropped |

## Verification
The bench drains channels down to zero one at a time. It then confirms that the empty channel receives no further grants while a credited neighbour keeps being served. A design that failed here would either send into a full far-end buffer or stall the whole link. It also lands a credit return in the same cycle as a grant, once at a partial level and once at the maximum. A faulty design would then lose or gain a credit, or raise a false error. It applies FIFO back-pressure with every channel requesting, and it checks that the rotation restarts at channel 0 after a mid-run reset. A wrong arbiter would show up as a starved channel or a write into a full FIFO.

// File: rtl/vc_credit_pkg.sv
package vc_credit_pkg;

    localparam int NUM_CH   = 3;
    localparam int CH_IDX_W = $clog2(NUM_CH);

    typedef enum logic [CH_IDX_W-1:0] {
        CH_POSTED    = 2'd0,
        CH_NONPOSTED = 2'd1,
        CH_RESPONSE  = 2'd2
    } vc_id_e;

    typedef struct packed {
        logic                wr;
        logic [CH_IDX_W-1:0] ch;
    } sched_t;

    // Round-robin pick: search starts one past the last winner.
    function automatic logic [NUM_CH-1:0] rr_pick(
        input logic [NUM_CH-1:0]   elig,
        input logic [CH_IDX_W-1:0] last
    );
        logic [NUM_CH-1:0] g;
        g = '0;
        for (int off = NUM_CH; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % NUM_CH;
            if (elig[idx]) begin
                g      = '0;
                g[idx] = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic [CH_IDX_W-1:0] onehot_idx(input logic [NUM_CH-1:0] oh);
        logic [CH_IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (oh[i]) r = CH_IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vc_credit_counter.sv
module vc_credit_counter #(
    parameter int MAX_CREDIT  = 8,
    parameter int INIT_CREDIT = 8,
    parameter int W           = $clog2(MAX_CREDIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic         give,
    output logic [W-1:0] level,
    output logic         ovf_err
);
    localparam logic [W-1:0] MAX_L  = W'(MAX_CREDIT);
    localparam logic [W-1:0] INIT_L = W'(INIT_CREDIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= INIT_L;
            ovf_err <= 1'b0;
        end else begin
            ovf_err <= 1'b0;
            if (take && !give) begin
                level <= level - 1'b1;
            end else if (give && !take) begin
                if (level == MAX_L) ovf_err <= 1'b1;
                else                level   <= level + 1'b1;
            end
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        level <= MAX_L);
    p_zero_nogrant_r3: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> !take);
    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !give) |=> level == W'($past(level) - 1'b1));
    p_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (give && !take && level != MAX_L) |=> level == W'($past(level) + 1'b1));
    p_net_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (give && take) |=> $stable(level));
endmodule

// File: rtl/vc_rr_arbiter.sv
module vc_rr_arbiter
    import vc_credit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] elig,
    input  logic              blocked,
    output logic [NUM_CH-1:0] gnt
);
    logic [CH_IDX_W-1:0] last_q;

    always_comb begin
        gnt = blocked ? '0 : rr_pick(elig, last_q);
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= CH_IDX_W'(NUM_CH - 1);
        else if (|gnt)  last_q <= onehot_idx(gnt);
    end

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_full_r9: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (gnt == '0));
    p_elig_r4: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~elig) == '0);
    p_work_r4: assert property (@(posedge clk) disable iff (rst)
        (!blocked && elig != '0) |-> (gnt != '0));
endmodule

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker
    import vc_credit_pkg::*;
#(
    parameter int MAX_CREDIT  = 8,
    parameter int INIT_CREDIT = 8,
    parameter int W           = $clog2(MAX_CREDIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     chan_req,
    input  logic                  fifo_full,
    input  logic [NUM_CH-1:0]     credit_ret,
    output logic [NUM_CH-1:0]     chan_grant,
    output logic                  fifo_wr,
    output logic [CH_IDX_W-1:0]   fifo_ch,
    output logic [NUM_CH*W-1:0]   credit_level,
    output logic                  credit_err
);
    logic [NUM_CH-1:0] has_credit;
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] ch_err;
    sched_t            sched;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        vc_credit_counter #(
            .MAX_CREDIT (MAX_CREDIT),
            .INIT_CREDIT(INIT_CREDIT),
            .W          (W)
        ) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .take   (chan_grant[c]),
            .give   (credit_ret[c]),
            .level  (credit_level[c*W +: W]),
            .ovf_err(ch_err[c])
        );
        assign has_credit[c] = (credit_level[c*W +: W] != '0);
    end

    assign elig = chan_req & has_credit;

    vc_rr_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .elig   (elig),
        .blocked(fifo_full),
        .gnt    (chan_grant)
    );

    always_comb begin
        sched.wr = |chan_grant;
        sched.ch = onehot_idx(chan_grant);
    end

    assign fifo_wr    = sched.wr;
    assign fifo_ch    = sched.ch;
    assign credit_err = |ch_err;

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> !fifo_wr);
    p_wr_full_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_wr);
endmodule

// File: tb/vc_credit_tracker_bench.sv
module vc_credit_tracker_bench;
    localparam int MAXC = 3;
    localparam int INIT = 2;
    localparam int W    = 2;
    localparam int NV   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] chan_req = '0;
    logic       fifo_full = 1'b0;
    logic [2:0] credit_ret = '0;
    logic [2:0] chan_grant;
    logic       fifo_wr;
    logic [1:0] fifo_ch;
    logic [5:0] credit_level;
    logic       credit_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vc_credit_tracker #(.MAX_CREDIT(MAXC), .INIT_CREDIT(INIT), .W(W)) u_vc_credit_tracker (
        .clk(clk), .rst(rst), .chan_req(chan_req), .fifo_full(fifo_full),
        .credit_ret(credit_ret), .chan_grant(chan_grant), .fifo_wr(fifo_wr),
        .fifo_ch(fifo_ch), .credit_level(credit_level), .credit_err(credit_err)
    );

    // {req, full, ret, exp_grant, exp_levels {c2,c1,c0} after edge, exp_err after edge}
    localparam logic [16:0] VEC [NV] = '{
        {3'b111, 1'b0, 3'b000, 3'b001, 2'd2, 2'd2, 2'd1, 1'b0}, // R2 R8 ch0 first
        {3'b111, 1'b0, 3'b000, 3'b010, 2'd2, 2'd1, 2'd1, 1'b0}, // R8 rotate
        {3'b111, 1'b0, 3'b000, 3'b100, 2'd1, 2'd1, 2'd1, 1'b0}, // R8
        {3'b111, 1'b1, 3'b000, 3'b000, 2'd1, 2'd1, 2'd1, 1'b0}, // R9 full
        {3'b001, 1'b0, 3'b000, 3'b001, 2'd1, 2'd1, 2'd0, 1'b0}, // R2 drain ch0
        {3'b001, 1'b0, 3'b000, 3'b000, 2'd1, 2'd1, 2'd0, 1'b0}, // R3 R6 idle
        {3'b011, 1'b0, 3'b000, 3'b010, 2'd1, 2'd0, 2'd0, 1'b0}, // R4 ch1 served
        {3'b001, 1'b0, 3'b001, 3'b000, 2'd1, 2'd0, 2'd1, 1'b0}, // R3 R5 return
        {3'b001, 1'b0, 3'b001, 3'b001, 2'd1, 2'd0, 2'd1, 1'b0}, // R7 net zero
        {3'b000, 1'b0, 3'b110, 3'b000, 2'd2, 2'd1, 2'd1, 1'b0}, // R5 two returns
        {3'b000, 1'b0, 3'b100, 3'b000, 2'd3, 2'd1, 2'd1, 1'b0}, // R5 reach max
        {3'b000, 1'b0, 3'b100, 3'b000, 2'd3, 2'd1, 2'd1, 1'b1}, // R10 overflow
        {3'b100, 1'b0, 3'b100, 3'b100, 2'd3, 2'd1, 2'd1, 1'b0}, // R7 R10 at max
        {3'b111, 1'b0, 3'b000, 3'b001, 2'd3, 2'd1, 2'd0, 1'b0}, // R8
        {3'b111, 1'b0, 3'b000, 3'b010, 2'd3, 2'd0, 2'd0, 1'b0}, // R8
        {3'b111, 1'b0, 3'b000, 3'b100, 2'd2, 2'd0, 2'd0, 1'b0}  // R4 only ch2 left
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [2:0] oh);
        return oh[2] ? 2 : (oh[1] ? 1 : 0);
    endfunction

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 reset levels", int'(credit_level), 6'b10_10_10);
        chk("R6 reset idle", int'({fifo_wr, chan_grant}), 0);
        chk("R10 reset err", int'(credit_err), 0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            chan_req   = VEC[v][16:14];
            fifo_full  = VEC[v][13];
            credit_ret = VEC[v][12:10];
            #2;
            chk("R8 R9 R3 grant", int'(chan_grant), int'(VEC[v][9:7]));
            chk("R2 R6 fifo_wr", int'(fifo_wr), int'(|VEC[v][9:7]));
            if (|VEC[v][9:7])
                chk("R2 fifo_ch", int'(fifo_ch), idx_of(VEC[v][9:7]));
            @(posedge clk);
            #2;
            chk("R1 R5 R7 levels", int'(credit_level), int'(VEC[v][6:1]));
            chk("R10 err", int'(credit_err), int'(VEC[v][0]));
        end

        @(negedge clk);
        chan_req = '0; credit_ret = '0; fifo_full = 1'b0;
        @(posedge clk); #2;
        chk("R10 err one cycle", int'(credit_err), 0);

        // mid-run reset: levels reload, rotation restarts at channel 0
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 reload", int'(credit_level), 6'b10_10_10);
        chan_req = 3'b111;
        #1;
        chk("R8 restart ch0", int'(chan_grant), 3'b001);
        @(negedge clk);
        chan_req = '0;
        #2;
        chk("R2 ch0 decremented", int'(credit_level), 6'b10_10_01);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule